// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date for a system that already has a one-pulse-per-second timebase. Each tick advances seconds. Carries then ripple through minutes, hours, day of week, day of month, month, year and century. Every field is held as a packed BCD byte, so software can show it without any conversion.

The hours byte carries its own format. With bit 7 clear it counts 00 to 23. With bit 7 set it counts 12, then 01 to 11, with bit 5 as the afternoon flag. The day of the month wraps at the true end of each month, and February gains its 29th day in years divisible by four.

A host sets the time by presenting all eight field values and pulsing a load strobe for one cycle. The new values take effect together on that edge and never mix with an increment. A tick that arrives in the same cycle as a load is held back by one cycle and then applied to the new time.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read seconds 00h, minutes 00h, hours 00h (24-hour mode), date 01h, month 01h, day-of-week 01h, year 00h and century 19h.
- R2: Seconds and minutes count in packed BCD from 00h to 59h. A tick at seconds 59h gives 00h and advances minutes, and minutes at 59h wrap to 00h and advance the hours.
- R3: With hours bit 7 at 0, bits 5:0 count in BCD from 00h to 23h. The step from 23h to 00h advances the day.
- R4: With hours bit 7 at 1, bits 4:0 hold BCD 01h..12h and bit 5 is the PM flag. The order is 12 AM, 1 to 11 AM, 12 PM, 1 to 11 PM. The flag toggles on the step from 11 to 12, and 11 PM to 12 AM (byte B1h to 92h) advances the day.
- R5: On a day carry the date advances, and it wraps to 01h after 30h in months 04h, 06h, 09h and 11h, and after 31h in the other months except February.
- R6: In February the date wraps after 29h when the BCD year is divisible by four (00h counts as leap) and after 28h otherwise.
- R7: The month counts 01h..12h. The step from 12h to 01h advances the year, and the year step from 99h to 00h advances the century, which wraps from 99h to 00h.
- R8: The day of week counts 01h..07h, wraps to 01h, and advances on every day carry.
- R9: A cycle with the load strobe high copies all eight load inputs into the fields on that clock edge with no increment. Loading 31h, 11h, B0h, 04h, 07h, 05h, 02h reads back as 10:11:31 PM, July 4, day-of-week 5, year 02.
- R10: When the load strobe and a tick arrive in the same cycle, the load wins and exactly one increment is applied on the following edge.
- R11: In a cycle with neither tick nor load, and no load in the cycle before, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| load_i | input | 1 | One-cycle strobe that loads all fields |
| ld_sec_i | input | 8 | Seconds value to load (BCD) |
| ld_min_i | input | 8 | Minutes value to load (BCD) |
| ld_hour_i | input | 8 | Hours value to load, with mode and PM bits |
| ld_date_i | input | 8 | Day of month to load (BCD) |
| ld_mon_i | input | 8 | Month to load (BCD) |
| ld_dow_i | input | 8 | Day of week to load (BCD) |
| ld_year_i | input | 8 | Year within century to load (BCD) |
| ld_cent_i | input | 8 | Century to load (BCD) |
| sec_o | output | 8 | Current seconds |
| min_o | output | 8 | Current minutes |
| hour_o | output | 8 | Current hours with mode and PM bits |
| date_o | output | 8 | Current day of month |
| mon_o | output | 8 | Current month |
| dow_o | output | 8 | Current day of week |
| year_o | output | 8 | Current year within century |
| cent_o | output | 8 | Current century |

## Verification
The range assertions assume that every loaded byte is a legal BCD value for its field, with a date that exists in the loaded month and year. They also assume that two ticks are never closer than two cycles, because a deferred tick would otherwise merge with the next one. The bench's random loads draw the month and year first and pick the date from that month's real length. It spaces ticks by at least one idle cycle, and it places a tick on a load only when the following cycle carries neither load nor tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int unsigned BCD_W = 8;

   typedef logic [BCD_W-1:0] bcd8_t;

   // two-digit BCD increment without wrap handling
   function automatic bcd8_t bcd_inc(bcd8_t v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by four: even tens need ones of 0/4/8, odd tens need 2/6
   function automatic logic bcd_leap(bcd8_t y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic bcd8_t bcd_last_day(bcd8_t mon, logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic bcd_ok(bcd8_t v);
      return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
   endfunction

endpackage

// File: rtl/rtc_bcd_wrap_cnt.sv
module rtc_bcd_wrap_cnt
   import rtc_cal_pkg::*;
#(
   parameter bcd8_t LO_VAL  = 8'h00,
   parameter bcd8_t HI_VAL  = 8'h59,
   parameter bcd8_t RST_VAL = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  bcd8_t load_val_i,
   input  logic  inc_i,
   output bcd8_t val_o,
   output logic  at_hi_o
);

   if (!bcd_ok(LO_VAL) || !bcd_ok(HI_VAL) || !bcd_ok(RST_VAL)) begin : g_bad_bcd
      $error("rtc_bcd_wrap_cnt: parameters must be BCD");
   end
   if (LO_VAL >= HI_VAL) begin : g_bad_range
      $error("rtc_bcd_wrap_cnt: LO_VAL must be below HI_VAL");
   end

   bcd8_t cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= RST_VAL;
      else if (load_i)  cnt_q <= load_val_i;
      else if (inc_i)   cnt_q <= (cnt_q == HI_VAL) ? LO_VAL : bcd_inc(cnt_q);
   end

   assign val_o   = cnt_q;
   assign at_hi_o = (cnt_q == HI_VAL);

endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt
   import rtc_cal_pkg::*;
#(
   parameter bcd8_t RST_VAL = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  bcd8_t load_val_i,
   input  logic  inc_i,
   output bcd8_t val_o,
   output logic  day_wrap_o
);

   if (RST_VAL[7] ? (RST_VAL[4:0] == 5'h00 || {3'b000, RST_VAL[4:0]} > 8'h12)
                  : ({2'b00, RST_VAL[5:0]} > 8'h23)) begin : g_bad_rst
      $error("rtc_hour_cnt: RST_VAL is not a legal hour");
   end

   bcd8_t hr_q;
   bcd8_t hr_nx;
   logic  mode12;
   logic  pm;
   bcd8_t h12;
   bcd8_t h24;

   assign mode12 = hr_q[7];
   assign pm     = hr_q[5];
   assign h12    = {3'b000, hr_q[4:0]};
   assign h24    = {2'b00, hr_q[5:0]};

   always_comb begin
      if (mode12) begin
         if (h12 == 8'h12)      hr_nx = {1'b1, 1'b0, pm,  5'h01};
         else if (h12 == 8'h11) hr_nx = {1'b1, 1'b0, ~pm, 5'h12};
         else begin
            hr_nx    = bcd_inc(h12);
            hr_nx[7] = 1'b1;
            hr_nx[5] = pm;
         end
      end else begin
         hr_nx = (h24 == 8'h23) ? 8'h00 : bcd_inc(h24);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      hr_q <= RST_VAL;
      else if (load_i) hr_q <= load_val_i;
      else if (inc_i)  hr_q <= hr_nx;
   end

   assign val_o      = hr_q;
   assign day_wrap_o = mode12 ? (pm && h12 == 8'h11) : (h24 == 8'h23);

endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
   import rtc_cal_pkg::*;
#(
   parameter bcd8_t RST_VAL = 8'h01
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  bcd8_t load_val_i,
   input  logic  inc_i,
   input  bcd8_t mon_i,
   input  bcd8_t year_i,
   output bcd8_t val_o,
   output logic  month_end_o
);

   if (!bcd_ok(RST_VAL) || RST_VAL == 8'h00 || RST_VAL > 8'h28) begin : g_bad_rst
      $error("rtc_date_cnt: RST_VAL must be a date valid in every month");
   end

   bcd8_t date_q;
   bcd8_t last_day;

   assign last_day = bcd_last_day(mon_i, bcd_leap(year_i));

   always_ff @(posedge clk) begin
      if (!rst_n)      date_q <= RST_VAL;
      else if (load_i) date_q <= load_val_i;
      else if (inc_i)  date_q <= (date_q == last_day) ? 8'h01 : bcd_inc(date_q);
   end

   assign val_o       = date_q;
   assign month_end_o = (date_q == last_day);

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter bcd8_t CENT_RST = 8'h19,
   parameter bcd8_t YEAR_RST = 8'h00,
   parameter bcd8_t HOUR_RST = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       load_i,
   input  logic [7:0] ld_sec_i,
   input  logic [7:0] ld_min_i,
   input  logic [7:0] ld_hour_i,
   input  logic [7:0] ld_date_i,
   input  logic [7:0] ld_mon_i,
   input  logic [7:0] ld_dow_i,
   input  logic [7:0] ld_year_i,
   input  logic [7:0] ld_cent_i,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] date_o,
   output logic [7:0] mon_o,
   output logic [7:0] dow_o,
   output logic [7:0] year_o,
   output logic [7:0] cent_o
);

   // plain wrap counters: 0 sec, 1 min, 2 dow, 3 month, 4 year, 5 century
   localparam int unsigned NWRAP = 6;
   localparam bcd8_t WR_LO  [NWRAP] = '{8'h00, 8'h00, 8'h01, 8'h01, 8'h00,  8'h00};
   localparam bcd8_t WR_HI  [NWRAP] = '{8'h59, 8'h59, 8'h07, 8'h12, 8'h99,  8'h99};
   localparam bcd8_t WR_RST [NWRAP] = '{8'h00, 8'h00, 8'h01, 8'h01, YEAR_RST, CENT_RST};

   bcd8_t wr_ld  [NWRAP];
   bcd8_t wr_val [NWRAP];
   logic  wr_inc [NWRAP];
   logic  wr_hi  [NWRAP];

   logic  tick_pend_q;
   logic  step;
   logic  hr_inc;
   logic  hr_day_wrap;
   logic  day_inc;
   logic  date_end;
   bcd8_t date_val;
   bcd8_t hour_val;

   // a tick that meets a load waits one cycle and then acts on the new time
   always_ff @(posedge clk) begin
      if (!rst_n) tick_pend_q <= 1'b0;
      else        tick_pend_q <= load_i & (tick_i | tick_pend_q);
   end

   assign step = (tick_i | tick_pend_q) & ~load_i;

   assign wr_ld[0] = ld_sec_i;
   assign wr_ld[1] = ld_min_i;
   assign wr_ld[2] = ld_dow_i;
   assign wr_ld[3] = ld_mon_i;
   assign wr_ld[4] = ld_year_i;
   assign wr_ld[5] = ld_cent_i;

   assign wr_inc[0] = step;
   assign wr_inc[1] = step & wr_hi[0];
   assign hr_inc    = wr_inc[1] & wr_hi[1];
   assign day_inc   = hr_inc & hr_day_wrap;
   assign wr_inc[2] = day_inc;
   assign wr_inc[3] = day_inc & date_end;
   assign wr_inc[4] = wr_inc[3] & wr_hi[3];
   assign wr_inc[5] = wr_inc[4] & wr_hi[4];

   for (genvar gi = 0; gi < NWRAP; gi++) begin : g_wrap
      rtc_bcd_wrap_cnt #(
         .LO_VAL  (WR_LO[gi]),
         .HI_VAL  (WR_HI[gi]),
         .RST_VAL (WR_RST[gi])
      ) cnt_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (load_i),
         .load_val_i (wr_ld[gi]),
         .inc_i      (wr_inc[gi]),
         .val_o      (wr_val[gi]),
         .at_hi_o    (wr_hi[gi])
      );
   end

   rtc_hour_cnt #(
      .RST_VAL (HOUR_RST)
   ) hour_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_val_i (ld_hour_i),
      .inc_i      (hr_inc),
      .val_o      (hour_val),
      .day_wrap_o (hr_day_wrap)
   );

   rtc_date_cnt #(
      .RST_VAL (8'h01)
   ) date_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_i),
      .load_val_i  (ld_date_i),
      .inc_i       (day_inc),
      .mon_i       (wr_val[3]),
      .year_i      (wr_val[4]),
      .val_o       (date_val),
      .month_end_o (date_end)
   );

   assign sec_o  = wr_val[0];
   assign min_o  = wr_val[1];
   assign hour_o = hour_val;
   assign date_o = date_val;
   assign mon_o  = wr_val[3];
   assign dow_o  = wr_val[2];
   assign year_o = wr_val[4];
   assign cent_o = wr_val[5];

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic       load_i,
   input logic [7:0] ld_sec_i,
   input logic [7:0] ld_min_i,
   input logic [7:0] ld_hour_i,
   input logic [7:0] ld_date_i,
   input logic [7:0] ld_mon_i,
   input logic [7:0] ld_dow_i,
   input logic [7:0] ld_year_i,
   input logic [7:0] ld_cent_i,
   input logic [7:0] sec_o,
   input logic [7:0] min_o,
   input logic [7:0] hour_o,
   input logic [7:0] date_o,
   input logic [7:0] mon_o,
   input logic [7:0] dow_o,
   input logic [7:0] year_o,
   input logic [7:0] cent_o
);

   assert_sec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_o[3:0] <= 4'd9) && (sec_o <= 8'h59) && (min_o[3:0] <= 4'd9) && (min_o <= 8'h59));

   assert_hour24_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !hour_o[7] |-> (hour_o[3:0] <= 4'd9) && ({2'b00, hour_o[5:0]} <= 8'h23));

   assert_hour12_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hour_o[7] |-> (hour_o[3:0] <= 4'd9) && (hour_o[4:0] != 5'h00) && ({3'b000, hour_o[4:0]} <= 8'h12));

   assert_date_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (date_o != 8'h00) && (date_o <= 8'h31) && (date_o[3:0] <= 4'd9));

   assert_month_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_o != 8'h00) && (mon_o <= 8'h12));

   assert_dow_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dow_o != 8'h00) && (dow_o <= 8'h07));

   assert_load_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sec_o == $past(ld_sec_i)) && (min_o == $past(ld_min_i)) &&
                 (hour_o == $past(ld_hour_i)) && (date_o == $past(ld_date_i)) &&
                 (mon_o == $past(ld_mon_i)) && (dow_o == $past(ld_dow_i)) &&
                 (year_o == $past(ld_year_i)) && (cent_o == $past(ld_cent_i)));

   assert_deferred_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && tick_i) ##1 !load_i |=> sec_o != $past(sec_o));

   assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i && !$past(load_i)) |=>
         $stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(date_o) &&
         $stable(mon_o) && $stable(dow_o) && $stable(year_o) && $stable(cent_o));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .load_i    (load_i),
   .ld_sec_i  (ld_sec_i),
   .ld_min_i  (ld_min_i),
   .ld_hour_i (ld_hour_i),
   .ld_date_i (ld_date_i),
   .ld_mon_i  (ld_mon_i),
   .ld_dow_i  (ld_dow_i),
   .ld_year_i (ld_year_i),
   .ld_cent_i (ld_cent_i),
   .sec_o     (sec_o),
   .min_o     (min_o),
   .hour_o    (hour_o),
   .date_o    (date_o),
   .mon_o     (mon_o),
   .dow_o     (dow_o),
   .year_o    (year_o),
   .cent_o    (cent_o)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       load_i = 1'b0;
   logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_date_i = '0;
   logic [7:0] ld_mon_i = '0, ld_dow_i = '0, ld_year_i = '0, ld_cent_i = '0;
   logic [7:0] sec_o, min_o, hour_o, date_o, mon_o, dow_o, year_o, cent_o;

   int checks = 0;
   int errors = 0;

   // reference state held as plain integers
   int m_sec, m_min, m_h24, m_date, m_mon, m_dow, m_year, m_cent;
   bit m_12;

   always #2 clk = ~clk;

   rtc_calendar_core dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
      .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i), .ld_date_i(ld_date_i),
      .ld_mon_i(ld_mon_i), .ld_dow_i(ld_dow_i), .ld_year_i(ld_year_i), .ld_cent_i(ld_cent_i),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
      .mon_o(mon_o), .dow_o(dow_o), .year_o(year_o), .cent_o(cent_o)
   );

   function automatic logic [7:0] to_bcd(int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int days_in(int mon, int year);
      if (mon == 2) return (year % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] hour_byte(int h24, bit is12);
      int h12;
      if (!is12) return to_bcd(h24);
      h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
      return 8'h80 | ((h24 >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
   endfunction

   function automatic logic [63:0] model_word();
      return {to_bcd(m_cent), to_bcd(m_year), to_bcd(m_dow), to_bcd(m_mon),
              to_bcd(m_date), hour_byte(m_h24, m_12), to_bcd(m_min), to_bcd(m_sec)};
   endfunction

   task automatic m_step();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_h24++;
            if (m_h24 == 24) begin
               m_h24 = 0;
               m_dow = (m_dow == 7) ? 1 : m_dow + 1;
               m_date++;
               if (m_date > days_in(m_mon, m_year)) begin
                  m_date = 1; m_mon++;
                  if (m_mon == 13) begin
                     m_mon = 1; m_year++;
                     if (m_year == 100) begin
                        m_year = 0; m_cent = (m_cent + 1) % 100;
                     end
                  end
               end
            end
         end
      end
   endtask

   task automatic compare(string tag);
      logic [63:0] act, exp;
      act = {cent_o, year_o, dow_o, mon_o, date_o, hour_o, min_o, sec_o};
      exp = model_word();
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_model(int c, int y, int dw, int mo, int d, int h24, bit is12, int mi, int s);
      m_cent = c; m_year = y; m_dow = dw; m_mon = mo; m_date = d;
      m_h24 = h24; m_12 = is12; m_min = mi; m_sec = s;
   endtask

   task automatic do_load(bit with_tick, string tag);
      @(negedge clk);
      {ld_cent_i, ld_year_i, ld_dow_i, ld_mon_i, ld_date_i, ld_hour_i, ld_min_i, ld_sec_i} = model_word();
      load_i = 1'b1;
      tick_i = with_tick;
      @(negedge clk);
      load_i = 1'b0;
      tick_i = 1'b0;
      compare(tag);
      if (with_tick) begin
         @(negedge clk);
         m_step();
         compare("R10 deferred tick");
      end
   endtask

   task automatic do_tick(string tag);
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      m_step();
      compare(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      set_model(19, 0, 1, 1, 1, 0, 1'b0, 0, 0);
      @(negedge clk);
      compare("R1 reset values");

      // R11: idle cycles change nothing
      repeat (4) @(negedge clk);
      compare("R11 idle hold");

      // R9: example load, 10:11:31 PM July 4, dow 5, year 02
      set_model(20, 2, 5, 7, 4, 22, 1'b1, 11, 31);
      do_load(1'b0, "R9 example load");
      checks++;
      if (hour_o !== 8'hB0) begin
         errors++;
         $display("FAIL R9 hour byte: actual %h expected b0", hour_o);
      end

      // R2: seconds and minutes carries
      set_model(20, 5, 3, 6, 10, 14, 1'b0, 58, 59);
      do_load(1'b0, "R2 load");
      do_tick("R2 minute carry");
      repeat (60) do_tick("R2 second count");

      // R3 and R5 and R7 and R8: full rollover into new century
      set_model(19, 99, 7, 12, 31, 23, 1'b0, 59, 59);
      do_load(1'b0, "R7 load");
      do_tick("R7 century rollover R3 R8");

      // R5: 30-day month
      set_model(20, 7, 2, 4, 30, 23, 1'b0, 59, 59);
      do_load(1'b0, "R5 load");
      do_tick("R5 april end");

      // R6: February common and leap years
      set_model(20, 3, 4, 2, 28, 23, 1'b0, 59, 59);
      do_load(1'b0, "R6 load");
      do_tick("R6 feb 28 common");
      set_model(20, 4, 4, 2, 28, 23, 1'b0, 59, 59);
      do_load(1'b0, "R6 load");
      do_tick("R6 feb 28 leap");
      set_model(20, 0, 4, 2, 29, 23, 1'b1, 59, 59);
      do_load(1'b0, "R6 load");
      do_tick("R6 feb 29 year 00 12h");

      // R4: 12-hour transitions
      set_model(20, 1, 1, 3, 3, 11, 1'b1, 59, 59);
      do_load(1'b0, "R4 load");
      do_tick("R4 11 AM to 12 PM");
      set_model(20, 1, 1, 3, 3, 0, 1'b1, 59, 59);
      do_load(1'b0, "R4 load");
      do_tick("R4 12 AM to 1 AM");
      set_model(20, 1, 1, 3, 3, 12, 1'b1, 59, 59);
      do_load(1'b0, "R4 load");
      do_tick("R4 12 PM to 1 PM");
      set_model(20, 1, 6, 3, 3, 23, 1'b1, 59, 59);
      do_load(1'b0, "R4 load");
      do_tick("R4 11 PM to 12 AM");

      // R10: load and tick together
      set_model(21, 10, 2, 8, 8, 9, 1'b0, 0, 59);
      do_load(1'b1, "R10 load wins");

      // random loads followed by ticks
      for (int n = 0; n < 80; n++) begin
         int mo, yr;
         mo = 1 + int'($urandom % 12);
         yr = int'($urandom % 100);
         set_model(int'($urandom % 100), yr, 1 + int'($urandom % 7), mo,
                   1 + int'($urandom % days_in(mo, yr)), int'($urandom % 24),
                   1'($urandom % 2),
                   ($urandom % 2) ? 59 : int'($urandom % 60),
                   ($urandom % 2) ? 59 : int'($urandom % 60));
         if ($urandom % 2) begin
            m_date = days_in(mo, yr);
            m_h24 = 23;
         end
         do_load(1'($urandom % 2), "R9 random load");
         for (int k = 0; k < 3; k++) do_tick("R5 random tick");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule